// File: doc/BRIEF.md
# ATA Task-File Command Loader

This block turns one ATA command request into the sequence of byte writes that a device's task-file register set expects. It works over a single byte-wide register port. It first selects the target unit in LBA mode and waits for the device's busy flag to drop, giving up after a configurable number of cycles. It then enables device interrupts and loads the feature, sector-count and address registers. It writes the command opcode last. In extended (48-bit) mode each parameter register is written twice, with the high-order byte first.

The same port also serves a readback operation. It rebuilds the sector count and logical block address that the device left in its registers. In extended mode it first sets the high-order-byte select in the control register to reach the earlier bytes, then clears it for the recent ones. A busy/done handshake toward the requester marks the end of either operation. For a load, a flag reports whether the busy wait timed out.

Top module: `taskfile_loader`

## Requirements
- R1: After reset `busy`, `done`, `regWe` and `regRe` are 0. No register access occurs while `busy` is 0.
- R2: A load request (`reqRead`=0) begins with one write to the drive register (address 6) of 0xE0 | (unit << 4): always-one bits 7 and 5, LBA bit 6, unit in bit 4.
- R3: After the select write, the block samples `devBsy` once per cycle. If it is set on TIMEOUT_CYC consecutive samples, the load ends with `done`=1 and `timedOut`=1, and no write follows the select write. Once `devBsy` is seen clear, the load proceeds. A clear sample in the last allowed cycle counts as success.
- R4: After the busy wait, the first write goes to the control register (address 14) with value 0x08 (bit 3 set, interrupt-disable bit 1 clear, high-order select bit 7 clear). It comes before any parameter write.
- R5: In 28-bit mode the writes after the control write are: feature (1) ← feature[7:0], count (2) ← count[7:0], sector (3) ← lba[7:0], cyl-low (4) ← lba[15:8], cyl-high (5) ← lba[23:16], drive (6) ← 0xE0 | unit<<4 | lba[27:24].
- R6: In 48-bit mode each register gets its high byte first: feature[15:8], feature[7:0]; count[15:8], count[7:0]; sector lba[31:24], lba[7:0]; cyl-low lba[39:32], lba[15:8]; cyl-high lba[47:40], lba[23:16]; then drive ← 0x40 | unit<<4.
- R7: The opcode is written to the command register (address 7) as the last write. `done` pulses with `timedOut`=0 in the next cycle.
- R8: At most one register access (write or read) happens per cycle.
- R9: A 48-bit readback writes 0x88 to control, reads count, sector, cyl-low and cyl-high, writes 0x08 to control, and reads the same four again. The result is `rdCount` = {first count, second count} and `rdLba` = {cyl-high, cyl-low, sector from the first pass; cyl-high, cyl-low, sector from the second pass}.
- R10: A 28-bit readback makes no writes. It reads count, sector, cyl-low, cyl-high and drive, and gives `rdCount` = {0, count} and `rdLba` = {20'b0, drive[3:0], cyl-high, cyl-low, sector}.
- R11: A request presented while `busy` is 1 is ignored: the running sequence's writes are unchanged.
- R12: `busy` rises in the cycle after a request is accepted. `done` is a one-cycle pulse during which `busy` is already 0, and the next request may be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, accepted when idle |
| reqRead | input | 1 | 1 = readback, 0 = command load |
| reqExt | input | 1 | 1 = 48-bit mode |
| reqUnit | input | 1 | Device unit select |
| reqFeature | input | 16 | Feature value |
| reqCount | input | 16 | Sector count |
| reqLba | input | 48 | Logical block address |
| reqOpcode | input | 8 | Command opcode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timedOut | output | 1 | Load aborted by busy-wait timeout (valid with done) |
| devBsy | input | 1 | Device busy flag |
| regWe | output | 1 | Register write strobe |
| regRe | output | 1 | Register read strobe |
| regAddr | output | 4 | Register address |
| regWdata | output | 8 | Write data |
| regRdata | input | 8 | Read data, valid in the cycle of regRe |
| rdCount | output | 16 | Rebuilt sector count |
| rdLba | output | 48 | Rebuilt logical block address |

## Verification
Two events can land in the same cycle: the device dropping its busy flag, and the wait counter reaching its limit. When both fall in the last allowed wait cycle, the clear flag must win. The bench provokes this by holding the busy flag for exactly the number of cycles that puts its release on that final sample, and one cycle longer for the abort case. It judges each outcome from the logged write sequence, the `timedOut` flag and the cycle count from request to `done`. Random trials with short and long busy windows also cross this boundary.

// File: rtl/tfl_pkg.sv
package tfl_pkg;
  localparam int STEP_W = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] ADDR_FEAT  = 4'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_SEC   = 4'd3;
  localparam logic [ADDR_W-1:0] ADDR_CYLLO = 4'd4;
  localparam logic [ADDR_W-1:0] ADDR_CYLHI = 4'd5;
  localparam logic [ADDR_W-1:0] ADDR_DRV   = 4'd6;
  localparam logic [ADDR_W-1:0] ADDR_CMD   = 4'd7;
  localparam logic [ADDR_W-1:0] ADDR_CTL   = 4'd14;

  localparam logic [DATA_W-1:0] CTL_LOW  = 8'h08;
  localparam logic [DATA_W-1:0] CTL_HIGH = 8'h88;
  localparam logic [DATA_W-1:0] DRV_SEL  = 8'hE0;
  localparam logic [DATA_W-1:0] DRV_EXT  = 8'h40;

  typedef enum logic [3:0] {
    CAP_NONE, CAP_CNT_HI, CAP_CNT_LO,
    CAP_L0, CAP_L1, CAP_L2, CAP_L3, CAP_L4, CAP_L5, CAP_NIB
  } cap_e;

  typedef struct packed {
    logic              load;
    logic              selWr;
    logic              run;
    logic [STEP_W-1:0] step;
  } tfl_strobe_t;

  typedef struct packed {
    logic              we;
    logic              re;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic              last;
    cap_e              cap;
  } access_t;

  function automatic access_t mkWr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d, logic last);
    access_t r;
    r.we = 1'b1; r.re = 1'b0; r.addr = a; r.data = d; r.last = last; r.cap = CAP_NONE;
    return r;
  endfunction

  function automatic access_t mkRd(logic [ADDR_W-1:0] a, cap_e c, logic last);
    access_t r;
    r.we = 1'b0; r.re = 1'b1; r.addr = a; r.data = '0; r.last = last; r.cap = c;
    return r;
  endfunction
endpackage

// File: rtl/tfl_ctrl.sv
module tfl_ctrl
  import tfl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic        devBsy,
  input  logic        lastStep,
  output tfl_strobe_t strobe,
  output logic        busy,
  output logic        done,
  output logic        timedOut
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SEL, ST_WAIT, ST_RUN} state_e;

  state_e            state;
  logic [CNT_W-1:0]  waitCnt;
  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      step     <= '0;
      done     <= 1'b0;
      timedOut <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (reqValid) begin
          state    <= reqRead ? ST_RUN : ST_SEL;
          step     <= '0;
          timedOut <= 1'b0;
        end
        ST_SEL: begin
          state   <= ST_WAIT;
          waitCnt <= '0;
        end
        ST_WAIT: begin
          if (!devBsy) begin
            state <= ST_RUN;
            step  <= '0;
          end else if (waitCnt == CNT_W'(TIMEOUT_CYC - 1)) begin
            state    <= ST_IDLE;
            done     <= 1'b1;
            timedOut <= 1'b1;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (lastStep) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.load  = (state == ST_IDLE) && reqValid;
    strobe.selWr = (state == ST_SEL);
    strobe.run   = (state == ST_RUN);
    strobe.step  = step;
  end

  assign busy = (state != ST_IDLE);

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT) |-> (32'(waitCnt) < TIMEOUT_CYC)); // R3
  AST_TIMEOUT_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> ($past(state) == ST_WAIT && $past(devBsy))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid) |=> busy); // R12
endmodule

// File: rtl/tfl_datapath.sv
module tfl_datapath
  import tfl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tfl_strobe_t       strobe,
  input  logic              reqRead,
  input  logic              reqExt,
  input  logic              reqUnit,
  input  logic [15:0]       reqFeature,
  input  logic [15:0]       reqCount,
  input  logic [47:0]       reqLba,
  input  logic [7:0]        reqOpcode,
  input  logic [DATA_W-1:0] regRdata,
  output logic              regWe,
  output logic              regRe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              lastStep,
  output logic [15:0]       rdCount,
  output logic [47:0]       rdLba
);
  logic        rdLat, extLat, unitLat;
  logic [15:0] featLat, cntLat;
  logic [47:0] lbaLat;
  logic [7:0]  opLat;
  logic [7:0]  unitBits;
  access_t     acc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdLat <= 1'b0; extLat <= 1'b0; unitLat <= 1'b0;
      featLat <= '0; cntLat <= '0; lbaLat <= '0; opLat <= '0;
    end else if (strobe.load) begin
      rdLat <= reqRead; extLat <= reqExt; unitLat <= reqUnit;
      featLat <= reqFeature; cntLat <= reqCount; lbaLat <= reqLba; opLat <= reqOpcode;
    end
  end

  assign unitBits = {3'b000, unitLat, 4'b0000};

  always_comb begin
    acc = '0;
    if (strobe.selWr) begin
      acc = mkWr(ADDR_DRV, DRV_SEL | unitBits, 1'b0);
    end else if (strobe.run) begin
      unique case ({rdLat, extLat})
        2'b00: case (strobe.step)
          4'd0: acc = mkWr(ADDR_CTL, CTL_LOW, 1'b0);
          4'd1: acc = mkWr(ADDR_FEAT, featLat[7:0], 1'b0);
          4'd2: acc = mkWr(ADDR_CNT, cntLat[7:0], 1'b0);
          4'd3: acc = mkWr(ADDR_SEC, lbaLat[7:0], 1'b0);
          4'd4: acc = mkWr(ADDR_CYLLO, lbaLat[15:8], 1'b0);
          4'd5: acc = mkWr(ADDR_CYLHI, lbaLat[23:16], 1'b0);
          4'd6: acc = mkWr(ADDR_DRV, DRV_SEL | unitBits | {4'b0000, lbaLat[27:24]}, 1'b0);
          default: acc = mkWr(ADDR_CMD, opLat, 1'b1);
        endcase
        2'b01: case (strobe.step)
          4'd0:  acc = mkWr(ADDR_CTL, CTL_LOW, 1'b0);
          4'd1:  acc = mkWr(ADDR_FEAT, featLat[15:8], 1'b0);
          4'd2:  acc = mkWr(ADDR_FEAT, featLat[7:0], 1'b0);
          4'd3:  acc = mkWr(ADDR_CNT, cntLat[15:8], 1'b0);
          4'd4:  acc = mkWr(ADDR_CNT, cntLat[7:0], 1'b0);
          4'd5:  acc = mkWr(ADDR_SEC, lbaLat[31:24], 1'b0);
          4'd6:  acc = mkWr(ADDR_SEC, lbaLat[7:0], 1'b0);
          4'd7:  acc = mkWr(ADDR_CYLLO, lbaLat[39:32], 1'b0);
          4'd8:  acc = mkWr(ADDR_CYLLO, lbaLat[15:8], 1'b0);
          4'd9:  acc = mkWr(ADDR_CYLHI, lbaLat[47:40], 1'b0);
          4'd10: acc = mkWr(ADDR_CYLHI, lbaLat[23:16], 1'b0);
          4'd11: acc = mkWr(ADDR_DRV, DRV_EXT | unitBits, 1'b0);
          default: acc = mkWr(ADDR_CMD, opLat, 1'b1);
        endcase
        2'b10: case (strobe.step)
          4'd0: acc = mkRd(ADDR_CNT, CAP_CNT_LO, 1'b0);
          4'd1: acc = mkRd(ADDR_SEC, CAP_L0, 1'b0);
          4'd2: acc = mkRd(ADDR_CYLLO, CAP_L1, 1'b0);
          4'd3: acc = mkRd(ADDR_CYLHI, CAP_L2, 1'b0);
          default: acc = mkRd(ADDR_DRV, CAP_NIB, 1'b1);
        endcase
        default: case (strobe.step)
          4'd0: acc = mkWr(ADDR_CTL, CTL_HIGH, 1'b0);
          4'd1: acc = mkRd(ADDR_CNT, CAP_CNT_HI, 1'b0);
          4'd2: acc = mkRd(ADDR_SEC, CAP_L3, 1'b0);
          4'd3: acc = mkRd(ADDR_CYLLO, CAP_L4, 1'b0);
          4'd4: acc = mkRd(ADDR_CYLHI, CAP_L5, 1'b0);
          4'd5: acc = mkWr(ADDR_CTL, CTL_LOW, 1'b0);
          4'd6: acc = mkRd(ADDR_CNT, CAP_CNT_LO, 1'b0);
          4'd7: acc = mkRd(ADDR_SEC, CAP_L0, 1'b0);
          4'd8: acc = mkRd(ADDR_CYLLO, CAP_L1, 1'b0);
          default: acc = mkRd(ADDR_CYLHI, CAP_L2, 1'b1);
        endcase
      endcase
    end
  end

  assign regWe    = acc.we;
  assign regRe    = acc.re;
  assign regAddr  = acc.addr;
  assign regWdata = acc.data;
  assign lastStep = acc.last;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdCount <= '0;
      rdLba   <= '0;
    end else if (strobe.load && reqRead) begin
      rdCount <= '0;
      rdLba   <= '0;
    end else if (acc.re) begin
      case (acc.cap)
        CAP_CNT_HI: rdCount[15:8] <= regRdata;
        CAP_CNT_LO: rdCount[7:0]  <= regRdata;
        CAP_L0:     rdLba[7:0]    <= regRdata;
        CAP_L1:     rdLba[15:8]   <= regRdata;
        CAP_L2:     rdLba[23:16]  <= regRdata;
        CAP_L3:     rdLba[31:24]  <= regRdata;
        CAP_L4:     rdLba[39:32]  <= regRdata;
        CAP_L5:     rdLba[47:40]  <= regRdata;
        CAP_NIB:    rdLba[27:24]  <= regRdata[3:0];
        default:    ;
      endcase
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe)); // R8
  AST_CTL_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selWr) |-> (regAddr == ADDR_DRV && regWdata[6])); // R2
endmodule

// File: rtl/taskfile_loader.sv
module taskfile_loader
  import tfl_pkg::*;
#(
  parameter int TIMEOUT_CYC = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqRead,
  input  logic        reqExt,
  input  logic        reqUnit,
  input  logic [15:0] reqFeature,
  input  logic [15:0] reqCount,
  input  logic [47:0] reqLba,
  input  logic [7:0]  reqOpcode,
  output logic        busy,
  output logic        done,
  output logic        timedOut,
  input  logic        devBsy,
  output logic        regWe,
  output logic        regRe,
  output logic [3:0]  regAddr,
  output logic [7:0]  regWdata,
  input  logic [7:0]  regRdata,
  output logic [15:0] rdCount,
  output logic [47:0] rdLba
);
  tfl_strobe_t strobe;
  logic        lastStep;

  tfl_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead),
    .devBsy(devBsy), .lastStep(lastStep), .strobe(strobe),
    .busy(busy), .done(done), .timedOut(timedOut)
  );

  tfl_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqRead(reqRead), .reqExt(reqExt),
    .reqUnit(reqUnit), .reqFeature(reqFeature), .reqCount(reqCount), .reqLba(reqLba),
    .reqOpcode(reqOpcode), .regRdata(regRdata), .regWe(regWe), .regRe(regRe),
    .regAddr(regAddr), .regWdata(regWdata), .lastStep(lastStep),
    .rdCount(rdCount), .rdLba(rdLba)
  );

  AST_CMD_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_CMD) |=> (done && !timedOut)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(regWe || regRe)); // R1
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R12
endmodule

// File: tb/taskfile_loader_bench.sv
module taskfile_loader_bench;
  import tfl_pkg::*;
  localparam int TMO = 64;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 0, reqRead = 0, reqExt = 0, reqUnit = 0;
  logic [15:0] reqFeature = '0, reqCount = '0;
  logic [47:0] reqLba = '0;
  logic [7:0]  reqOpcode = '0;
  logic busy, done, timedOut, devBsy, regWe, regRe;
  logic [3:0] regAddr;
  logic [7:0] regWdata, regRdata;
  logic [15:0] rdCount;
  logic [47:0] rdLba;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  taskfile_loader #(.TIMEOUT_CYC(TMO)) u_taskfile_loader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqRead(reqRead), .reqExt(reqExt),
    .reqUnit(reqUnit), .reqFeature(reqFeature), .reqCount(reqCount), .reqLba(reqLba),
    .reqOpcode(reqOpcode), .busy(busy), .done(done), .timedOut(timedOut), .devBsy(devBsy),
    .regWe(regWe), .regRe(regRe), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .rdCount(rdCount), .rdLba(rdLba)
  );

  // cycle counter and busy-flag model
  int unsigned cyc = 0;
  int unsigned busyUntil = 0;
  always @(posedge clk) cyc <= cyc + 1;
  assign devBsy = (cyc < busyUntil);

  // device register model with high-order select
  logic [7:0] loRegs [16];
  logic [7:0] hiRegs [16];
  logic hob = 1'b0;
  always @(posedge clk) if (regWe && regAddr == ADDR_CTL) hob <= regWdata[7];
  assign regRdata = hob ? hiRegs[regAddr] : loRegs[regAddr];

  // access logs
  logic [11:0] wLog [256];
  logic [3:0]  rLog [256];
  logic [7:0]  wTot = 0, rTot = 0;
  always @(posedge clk) begin
    if (regWe) begin wLog[wTot] <= {regAddr, regWdata}; wTot <= wTot + 1; end
    if (regRe) begin rLog[rTot] <= regAddr; rTot <= rTot + 1; end
  end

  logic [11:0] expW [16];
  int expN;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [3:0] a, logic [7:0] d);
    expW[expN] = {a, d};
    expN++;
  endtask

  task automatic buildExp(logic u, logic [15:0] f, logic [15:0] c, logic [47:0] l,
                          logic [7:0] op, logic ext, bit tmo);
    logic [7:0] ub;
    ub = {3'b0, u, 4'b0};
    expN = 0;
    push(ADDR_DRV, 8'hE0 | ub);
    if (!tmo) begin
      push(ADDR_CTL, 8'h08);
      if (ext) begin
        push(ADDR_FEAT, f[15:8]);  push(ADDR_FEAT, f[7:0]);
        push(ADDR_CNT, c[15:8]);   push(ADDR_CNT, c[7:0]);
        push(ADDR_SEC, l[31:24]);  push(ADDR_SEC, l[7:0]);
        push(ADDR_CYLLO, l[39:32]); push(ADDR_CYLLO, l[15:8]);
        push(ADDR_CYLHI, l[47:40]); push(ADDR_CYLHI, l[23:16]);
        push(ADDR_DRV, 8'h40 | ub);
      end else begin
        push(ADDR_FEAT, f[7:0]);
        push(ADDR_CNT, c[7:0]);
        push(ADDR_SEC, l[7:0]);
        push(ADDR_CYLLO, l[15:8]);
        push(ADDR_CYLHI, l[23:16]);
        push(ADDR_DRV, 8'hE0 | ub | {4'b0, l[27:24]});
      end
      push(ADDR_CMD, op);
    end
  endtask

  task automatic runLoad(logic u, logic [15:0] f, logic [15:0] c, logic [47:0] l,
                         logic [7:0] op, logic ext, int n, bit intrude);
    logic [7:0] base;
    int lat, bw, expLat;
    bit tmo;
    string tag;
    tmo = (n >= TMO + 2);
    bw = (n > 2) ? n - 2 : 0;
    expLat = tmo ? TMO + 1 : 2 + bw + (ext ? 13 : 8);
    buildExp(u, f, c, l, op, ext, tmo);
    @(negedge clk);
    reqUnit = u; reqFeature = f; reqCount = c; reqLba = l; reqOpcode = op;
    reqExt = ext; reqRead = 0; reqValid = 1;
    busyUntil = cyc + n;
    base = wTot;
    @(negedge clk);
    reqValid = 0;
    check(busy == 1'b1, "R12", "busy after accept", 64'(busy), 1);
    if (intrude) begin
      reqValid = 1; reqRead = 1; reqExt = ~ext; reqOpcode = ~op; reqUnit = ~u;
    end
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat >= 3) reqValid = 0;
    end while (!done && lat < 600);
    reqValid = 0;
    check(done == 1'b1, "R12", "done pulse seen", 64'(done), 1);
    check(timedOut == tmo, "R3", "timeout flag", 64'(timedOut), 64'(tmo));
    check(lat == expLat, tmo ? "R3" : "R7", "request-to-done cycles", 64'(lat), 64'(expLat));
    check(int'(8'(wTot - base)) == expN, intrude ? "R11" : (tmo ? "R3" : "R7"),
          "write count", 64'(8'(wTot - base)), 64'(expN));
    for (int i = 0; i < expN && i < int'(8'(wTot - base)); i++) begin
      if (i == 0) tag = "R2";
      else if (i == 1) tag = "R4";
      else if (i == expN - 1) tag = "R7";
      else tag = ext ? "R6" : "R5";
      if (intrude) tag = {tag, "/R11"};
      check(wLog[8'(base + i)] == expW[i], tag, $sformatf("write %0d addr+data", i),
            64'(wLog[8'(base + i)]), 64'(expW[i]));
    end
    @(negedge clk);
    check(!done && !busy, "R12", "done is one cycle, idle after", 64'({done, busy}), 0);
  endtask

  task automatic runRead(logic ext);
    logic [7:0] wb, rb;
    int lat, expLat;
    logic [15:0] eCnt;
    logic [47:0] eLba;
    logic [3:0] eAddr [10];
    int eReads;
    string tag;
    tag = ext ? "R9" : "R10";
    @(negedge clk);
    for (int a = 2; a <= 6; a++) begin
      loRegs[a] = 8'($urandom);
      hiRegs[a] = 8'($urandom);
    end
    if (ext) begin
      eCnt = {hiRegs[2], loRegs[2]};
      eLba = {hiRegs[5], hiRegs[4], hiRegs[3], loRegs[5], loRegs[4], loRegs[3]};
      eReads = 8;
      for (int i = 0; i < 8; i++) eAddr[i] = 4'(2 + (i % 4));
    end else begin
      eCnt = {8'h00, loRegs[2]};
      eLba = {20'h0, loRegs[6][3:0], loRegs[5], loRegs[4], loRegs[3]};
      eReads = 5;
      for (int i = 0; i < 5; i++) eAddr[i] = 4'(2 + i);
    end
    expLat = ext ? 10 : 5;
    reqRead = 1; reqExt = ext; reqValid = 1;
    wb = wTot; rb = rTot;
    @(negedge clk);
    reqValid = 0;
    check(busy == 1'b1, "R12", "busy after readback accept", 64'(busy), 1);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 600);
    check(lat == expLat, tag, "readback cycles", 64'(lat), 64'(expLat));
    check(rdCount == eCnt, tag, "rebuilt count", 64'(rdCount), 64'(eCnt));
    check(rdLba == eLba, tag, "rebuilt lba", 64'(rdLba), 64'(eLba));
    check(int'(8'(rTot - rb)) == eReads, tag, "read count", 64'(8'(rTot - rb)), 64'(eReads));
    for (int i = 0; i < eReads && i < int'(8'(rTot - rb)); i++)
      check(rLog[8'(rb + i)] == eAddr[i], tag, $sformatf("read %0d addr", i),
            64'(rLog[8'(rb + i)]), 64'(eAddr[i]));
    if (ext) begin
      check(8'(wTot - wb) == 8'd2, "R9", "control write count", 64'(8'(wTot - wb)), 2);
      check(wLog[wb] == {ADDR_CTL, 8'h88}, "R9", "high select write", 64'(wLog[wb]),
            64'({ADDR_CTL, 8'h88}));
      check(wLog[8'(wb + 1)] == {ADDR_CTL, 8'h08}, "R9", "low select write",
            64'(wLog[8'(wb + 1)]), 64'({ADDR_CTL, 8'h08}));
    end else begin
      check(8'(wTot - wb) == 8'd0, "R10", "no writes", 64'(8'(wTot - wb)), 0);
    end
    reqRead = 0;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    for (int a = 0; a < 16; a++) begin loRegs[a] = 8'h00; hiRegs[a] = 8'h00; end
    repeat (4) @(negedge clk);
    check(!busy && !done && !regWe && !regRe, "R1", "state in reset",
          64'({busy, done, regWe, regRe}), 0);
    rstN = 1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !regWe && !regRe, "R1", "idle after reset",
          64'({busy, done, regWe, regRe}), 0);

    // directed corners
    runLoad(1'b0, 16'h1234, 16'h0056, 48'h0000_0A1B_2C3D, 8'hC8, 1'b0, 0, 0);   // R5
    runLoad(1'b1, 16'hA5C3, 16'h0102, 48'hF1E2_D3C4_B5A6, 8'h25, 1'b1, 0, 0);   // R6
    runLoad(1'b1, 16'h0001, 16'h0002, 48'h0000_0F00_0000, 8'h35, 1'b0, 5, 0);   // R3 short wait
    runLoad(1'b0, 16'h00FF, 16'h00AA, 48'h0000_0123_4567, 8'hCA, 1'b0, TMO + 1, 0); // R3 clear on last sample
    runLoad(1'b1, 16'h00FF, 16'h00AA, 48'h0000_0123_4567, 8'hCA, 1'b1, TMO + 2, 0); // R3 timeout
    runLoad(1'b0, 16'h7788, 16'h99AA, 48'h1122_3344_5566, 8'h24, 1'b1, 20, 1);  // R11
    runRead(1'b0);  // R10
    runRead(1'b1);  // R9
    runRead(1'b0);  // R10 after extended readback

    // random mix
    for (int t = 0; t < 40; t++) begin
      int kind, n;
      kind = int'($urandom % 3);
      n = int'($urandom % 8);
      if ($urandom % 6 == 0) n = TMO + int'($urandom % 4);
      if (kind == 2)
        runRead(1'($urandom));
      else
        runLoad(1'($urandom), 16'($urandom), 16'($urandom),
                {16'($urandom), 32'($urandom)}, 8'($urandom), kind == 1, n, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule